// File: doc/BRIEF.md
# DMA Channel Pointer and Count Unit

This block holds the addressing state of a two-channel DMA engine. Every channel carries a 20-bit source pointer, a 20-bit destination pointer and a 16-bit transfer counter. A byte-wide register port reaches all of them, with multi-byte fields stored little-endian. A control byte per channel does three things. It sets each pointer to fixed or incrementing mode. It picks a transfer unit of one or two bytes. It selects single or repeat operation and switches the channel on. The unit moves no data. An external engine pulses one strobe per completed transfer, and the unit then advances its pointers and counts down.

Each pointer keeps two copies. One is the value software last wrote. The other is a live copy that advances while the channel runs. A read returns the live copy only when that pointer increments and the channel is enabled. The counter works the same way in reverse. Software writes the count minus one into a reload register. The working counter takes that value when the channel is switched on. A read of the counter returns the working counter. When a strobe arrives with the counter at zero, the channel emits a one-clock end pulse. It then either stops or, in repeat mode, starts over.

Top module: `dxu_top`

## Requirements
- R1: After reset every control byte reads 0x00, so every channel is disabled, and no end pulse is asserted.
- R2: Register map per channel, with channel index in address bit 4. The source pointer is at offsets 0..2 and the destination pointer at offsets 4..6, low byte first. The counter is at offsets 8..9 and the control byte at offset 12. Unmapped offsets read 0. The upper nibble of pointer byte 2 is not stored and reads 0.
- R3: A pointer in fixed mode ignores writes while its channel is enabled.
- R4: A pointer in incrementing mode accepts writes at any time. A read returns the live pointer when that pointer increments and the channel is enabled. Otherwise it returns the last written value.
- R5: A write to the counter offsets updates only the reload register. A read of those offsets returns the working counter.
- R6: When the enable bit is written from 0 to 1, the working counter loads the reload value and both live pointers load their written values.
- R7: Control bit 0 sets the source pointer to increment and bit 1 does the same for the destination pointer. Bit 2 selects a 2-byte unit, and a 1-byte unit when clear. Bit 3 selects repeat mode and bit 4 is enable. While the channel is enabled and its counter is nonzero, a strobe adds the unit to each incrementing live pointer, leaves fixed pointers alone and decrements the counter. A strobe on a disabled channel has no effect.
- R8: In single mode, a strobe that finds the counter at 0 raises the end output for exactly the next clock and clears the enable bit. A control write in that cycle takes precedence.
- R9: In repeat mode, a strobe that finds the counter at 0 raises the end output for one clock. It reloads the counter and both live pointers, and the channel stays enabled.
- R10: The two channels are independent. Writes, strobes and end pulses of one channel never change the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 8 | Read byte, combinational from rd_addr |
| xfer_stb | input | 2 | One-cycle transfer-done strobe per channel |
| eot | output | 2 | One-cycle end-of-transfer pulse per channel |

## Verification
The assertions assume the following about the inputs. Software writes at most one byte per cycle. A transfer strobe is a single-cycle level sampled on the clock edge. Nothing drives the inputs until reset has been applied. The stimulus drives every input away from the active edge and uses only the one write port, so two register updates never collide. Counter values in the random phase are kept small, so underflow, repeat reload and single-mode stop all occur often. The enable bit is toggled while strobes and pointer writes are in flight.

// File: rtl/dxu_pkg.sv
// Shared constants for the DMA pointer/count unit.
// Assumes a byte-wide register port with 16 byte offsets per channel.
package dxu_pkg;
    localparam int PTR_W   = 20;
    localparam int PTR_NB  = 3;
    localparam int CNT_W   = 16;
    localparam int CNT_NB  = 2;
    localparam int OFF_W   = 4;
    // byte offsets inside one channel window
    localparam logic [OFF_W-1:0] OFF_SRC = 4'd0;
    localparam logic [OFF_W-1:0] OFF_DST = 4'd4;
    localparam logic [OFF_W-1:0] OFF_CNT = 4'd8;
    localparam logic [OFF_W-1:0] OFF_CTL = 4'd12;
    // control byte bit positions
    localparam int CB_SFWD = 0;
    localparam int CB_DFWD = 1;
    localparam int CB_UNIT = 2;
    localparam int CB_RPT  = 3;
    localparam int CB_EN   = 4;
endpackage

// File: rtl/dxu_pointer.sv
// One address pointer: a software-written copy plus a live copy that advances.
// Assumes load and rewind never coincide with a write to this pointer.
module dxu_pointer #(
    parameter int W  = 20,
    parameter int NB = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [1:0]   wr_idx,
    input  logic [7:0]   wr_data,
    input  logic         en,
    input  logic         fwd,
    input  logic         unit2,
    input  logic         load,
    input  logic         rewind,
    input  logic         step,
    output logic [W-1:0] rd_val
);
    localparam int PW = NB * 8;
    localparam logic [PW-1:0] KEEP = PW'((64'd1 << W) - 64'd1);

    logic [PW-1:0] wq;
    logic [PW-1:0] wnext;
    logic [W-1:0]  live;
    logic          wr_ok;

    assign wr_ok = wr_hit && (fwd || !en);

    // merge the incoming byte into the written copy
    always_comb begin
        wnext = wq;
        for (int b = 0; b < NB; b++) begin
            if (wr_idx == 2'(b)) wnext[b*8 +: 8] = wr_data;
        end
    end

    // written copy: accepted writes only, unstored bits forced to 0
    always_ff @(posedge clk) begin
        if (!rst_n)     wq <= '0;
        else if (wr_ok) wq <= wnext & KEEP;
    end

    // live copy: reload on start or repeat, otherwise step by the unit
    always_ff @(posedge clk) begin
        if (!rst_n)                live <= '0;
        else if (load || rewind)   live <= wq[W-1:0];
        else if (step && fwd)      live <= live + (unit2 ? W'(2) : W'(1));
    end

    assign rd_val = (fwd && en) ? live : wq[W-1:0];

    // fixed pointer is write-locked while its channel runs
    assert_fixed_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !fwd) |=> (wq == $past(wq)));
endmodule

// File: rtl/dxu_counter.sv
// Transfer counter: software reload register plus a working down-counter.
// Assumes load only when the channel is disabled, so it never meets a strobe.
module dxu_counter #(
    parameter int W  = 16,
    parameter int NB = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [1:0]   wr_idx,
    input  logic [7:0]   wr_data,
    input  logic         en,
    input  logic         rpt,
    input  logic         stb,
    input  logic         load,
    output logic         step,
    output logic         uflow,
    output logic [W-1:0] cnt
);
    logic [W-1:0] rel;

    assign step  = en && stb && (cnt != '0);
    assign uflow = en && stb && (cnt == '0);

    // reload register takes software bytes
    always_ff @(posedge clk) begin
        if (!rst_n) rel <= '0;
        else if (wr_hit) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_idx == 2'(b)) rel[b*8 +: 8] <= wr_data;
            end
        end
    end

    // working counter: load, repeat reload or decrement
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= rel;
        else if (uflow && rpt)    cnt <= rel;
        else if (step)            cnt <= cnt - W'(1);
    end

    // software writes alone never touch the working count
    assert_write_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !load && !(en && stb)) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/dxu_channel.sv
// One DMA channel: control byte, two pointers, counter and end pulse.
// Assumes the top decodes addresses and hands in one-hot hit strobes.
module dxu_channel
    import dxu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_hit,
    input  logic             dst_hit,
    input  logic             cnt_hit,
    input  logic             ctl_hit,
    input  logic [1:0]       wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             stb,
    output logic [PTR_W-1:0] src_rd,
    output logic [PTR_W-1:0] dst_rd,
    output logic [CNT_W-1:0] cnt_rd,
    output logic [7:0]       ctl_rd,
    output logic             eot
);
    logic sfwd, dfwd, unit2, rpt, en;
    logic load, step, uflow, rewind;

    assign load   = ctl_hit && wr_data[CB_EN] && !en;
    assign rewind = uflow && rpt;

    // control byte; software write wins over the hardware stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sfwd, dfwd, unit2, rpt, en} <= '0;
        end else if (ctl_hit) begin
            sfwd  <= wr_data[CB_SFWD];
            dfwd  <= wr_data[CB_DFWD];
            unit2 <= wr_data[CB_UNIT];
            rpt   <= wr_data[CB_RPT];
            en    <= wr_data[CB_EN];
        end else if (uflow && !rpt) begin
            en <= 1'b0;
        end
    end

    // end-of-transfer pulse follows an underflowing strobe
    always_ff @(posedge clk) begin
        if (!rst_n) eot <= 1'b0;
        else        eot <= uflow;
    end

    assign ctl_rd = {3'b000, en, rpt, unit2, dfwd, sfwd};

    dxu_pointer #(.W(PTR_W), .NB(PTR_NB)) u_src (
        .clk(clk), .rst_n(rst_n), .wr_hit(src_hit), .wr_idx(wr_idx),
        .wr_data(wr_data), .en(en), .fwd(sfwd), .unit2(unit2),
        .load(load), .rewind(rewind), .step(step), .rd_val(src_rd));

    dxu_pointer #(.W(PTR_W), .NB(PTR_NB)) u_dst (
        .clk(clk), .rst_n(rst_n), .wr_hit(dst_hit), .wr_idx(wr_idx),
        .wr_data(wr_data), .en(en), .fwd(dfwd), .unit2(unit2),
        .load(load), .rewind(rewind), .step(step), .rd_val(dst_rd));

    dxu_counter #(.W(CNT_W), .NB(CNT_NB)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_hit(cnt_hit), .wr_idx(wr_idx),
        .wr_data(wr_data), .en(en), .rpt(rpt), .stb(stb), .load(load),
        .step(step), .uflow(uflow), .cnt(cnt_rd));

    assert_single_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stb && cnt_rd == '0 && !rpt && !ctl_hit) |=> (!en && eot));
    assert_repeat_stay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stb && cnt_rd == '0 && rpt && !ctl_hit) |=> (en && eot));
    assert_idle_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> !eot);
endmodule

// File: rtl/dxu_top.sv
// Two-channel DMA pointer/count unit with a byte register port.
// Assumes one write per cycle; read data is combinational from rd_addr.
module dxu_top
    import dxu_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(NCH)+OFF_W-1:0] wr_addr,
    input  logic [7:0]                   wr_data,
    input  logic [$clog2(NCH)+OFF_W-1:0] rd_addr,
    output logic [7:0]                   rd_data,
    input  logic [NCH-1:0]               xfer_stb,
    output logic [NCH-1:0]               eot
);
    localparam int CH_W = $clog2(NCH);
    localparam int PPAD = PTR_NB * 8;

    logic [OFF_W-1:0] w_off, r_off;
    logic [CH_W-1:0]  w_ch, r_ch;
    logic [PTR_W-1:0] src_rd [NCH];
    logic [PTR_W-1:0] dst_rd [NCH];
    logic [CNT_W-1:0] cnt_rd [NCH];
    logic [7:0]       ctl_rd [NCH];

    assign w_off = wr_addr[OFF_W-1:0];
    assign w_ch  = wr_addr[OFF_W +: CH_W];
    assign r_off = rd_addr[OFF_W-1:0];
    assign r_ch  = rd_addr[OFF_W +: CH_W];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = wr_en && (w_ch == CH_W'(c));
        dxu_channel u_chan (
            .clk(clk), .rst_n(rst_n),
            .src_hit(sel && w_off[3:2] == OFF_SRC[3:2] && w_off[1:0] != 2'd3),
            .dst_hit(sel && w_off[3:2] == OFF_DST[3:2] && w_off[1:0] != 2'd3),
            .cnt_hit(sel && w_off[3:1] == OFF_CNT[3:1]),
            .ctl_hit(sel && w_off == OFF_CTL),
            .wr_idx(w_off[1:0]), .wr_data(wr_data), .stb(xfer_stb[c]),
            .src_rd(src_rd[c]), .dst_rd(dst_rd[c]), .cnt_rd(cnt_rd[c]),
            .ctl_rd(ctl_rd[c]), .eot(eot[c]));
    end

    // read mux: pick channel, field and byte
    always_comb begin
        logic [PPAD-1:0] sp, dp;
        sp = PPAD'(src_rd[r_ch]);
        dp = PPAD'(dst_rd[r_ch]);
        rd_data = 8'h00;
        if (r_off[3:2] == OFF_SRC[3:2] && r_off[1:0] != 2'd3)
            rd_data = sp[r_off[1:0]*8 +: 8];
        else if (r_off[3:2] == OFF_DST[3:2] && r_off[1:0] != 2'd3)
            rd_data = dp[r_off[1:0]*8 +: 8];
        else if (r_off[3:1] == OFF_CNT[3:1])
            rd_data = cnt_rd[r_ch][r_off[0]*8 +: 8];
        else if (r_off == OFF_CTL)
            rd_data = ctl_rd[r_ch];
    end

    // upper nibble of pointer byte 2 never carries data
    always_comb begin
        if (rst_n && r_off[1:0] == 2'd2 && !r_off[3])
            assert_ptr_top_R2: assert (rd_data[7:4] == 4'h0);
    end
endmodule

// File: tb/dxu_top_bench.sv
// Bench: behavioural model of both channels, compared on every clock.
module dxu_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] xfer_stb = '0;
    logic [1:0] eot;

    int errors = 0;
    int checks = 0;
    bit init_done = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dxu_top u_dxu_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .xfer_stb(xfer_stb), .eot(eot));

    // model state
    int unsigned m_sw_s[2], m_sw_d[2], m_lv_s[2], m_lv_d[2], m_rel[2], m_cnt[2];
    bit [7:0] m_ctl[2];
    bit m_eot[2];
    bit m_cnt_known[2];

    function automatic int unsigned put_byte(int unsigned v, int idx, bit [7:0] d);
        int unsigned m;
        m = 32'hFF << (8 * idx);
        return (v & ~m) | (int'(d) << (8 * idx));
    endfunction

    // model update at the clock edge from pre-edge state
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_ctl[c] = 8'h00; m_eot[c] = 1'b0; m_cnt_known[c] = 1'b0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit en, sf, df, rp, stb, uf, st, wh, cw, ld;
                int unsigned unit, off;
                int unsigned o_sw_s, o_sw_d, o_rel;
                en = m_ctl[c][4]; sf = m_ctl[c][0]; df = m_ctl[c][1]; rp = m_ctl[c][3];
                unit = m_ctl[c][2] ? 2 : 1;
                stb = xfer_stb[c];
                uf = en && stb && (m_cnt[c] == 0);
                st = en && stb && (m_cnt[c] != 0);
                wh = wr_en && (int'(wr_addr[4]) == c);
                off = wr_addr[3:0];
                cw = wh && off == 12;
                ld = cw && wr_data[4] && !en;
                o_sw_s = m_sw_s[c]; o_sw_d = m_sw_d[c]; o_rel = m_rel[c];
                if (wh && off <= 2 && (sf || !en))
                    m_sw_s[c] = put_byte(m_sw_s[c], off, wr_data) & 32'hFFFFF;
                if (wh && off >= 4 && off <= 6 && (df || !en))
                    m_sw_d[c] = put_byte(m_sw_d[c], off - 4, wr_data) & 32'hFFFFF;
                if (wh && (off == 8 || off == 9))
                    m_rel[c] = put_byte(m_rel[c], off - 8, wr_data);
                if (ld || (uf && rp)) begin
                    m_lv_s[c] = o_sw_s; m_lv_d[c] = o_sw_d;
                end else if (st) begin
                    if (sf) m_lv_s[c] = (m_lv_s[c] + unit) & 32'hFFFFF;
                    if (df) m_lv_d[c] = (m_lv_d[c] + unit) & 32'hFFFFF;
                end
                if (ld || (uf && rp)) m_cnt[c] = o_rel;
                else if (st)          m_cnt[c] = (m_cnt[c] - 1) & 32'hFFFF;
                if (ld) m_cnt_known[c] = 1'b1;
                if (cw)                 m_ctl[c] = wr_data & 8'h1F;
                else if (uf && !rp)     m_ctl[c][4] = 1'b0;
                m_eot[c] = uf;
            end
        end
    end

    // expected read byte; known=0 where the value is not yet defined
    function automatic bit [7:0] m_read(bit [4:0] a, output bit known, output string tag);
        int c, off;
        int unsigned v;
        bit en;
        c = a[4]; off = a[3:0]; en = m_ctl[c][4];
        known = 1'b1; tag = "R2";
        if (off <= 2) begin
            known = init_done; tag = "R4";
            v = (m_ctl[c][0] && en) ? m_lv_s[c] : m_sw_s[c];
            return 8'((v >> (8 * off)) & 32'hFF);
        end else if (off >= 4 && off <= 6) begin
            known = init_done; tag = "R4";
            v = (m_ctl[c][1] && en) ? m_lv_d[c] : m_sw_d[c];
            return 8'((v >> (8 * (off - 4))) & 32'hFF);
        end else if (off == 8 || off == 9) begin
            known = m_cnt_known[c]; tag = "R5";
            return 8'((m_cnt[c] >> (8 * (off - 8))) & 32'hFF);
        end else if (off == 12) begin
            tag = "R1";
            return m_ctl[c];
        end
        return 8'h00;
    endfunction

    // compare away from the edge, after the driver has settled inputs
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            bit kn;
            string tg;
            bit [7:0] ex;
            ex = m_read(rd_addr, kn, tg);
            if (kn) begin
                checks++;
                if (rd_data !== ex) begin
                    errors++;
                    $display("FAIL %s read addr=%0h actual=%02h expected=%02h",
                             tg, rd_addr, rd_data, ex);
                end
            end
            for (int c = 0; c < 2; c++) begin
                checks++;
                if (eot[c] !== m_eot[c]) begin
                    errors++;
                    $display("FAIL R8/R9 eot ch%0d actual=%0b expected=%0b",
                             c, eot[c], m_eot[c]);
                end
            end
        end
    end

    // one cycle of stimulus; the read address sweeps all offsets
    task automatic cyc(bit we, bit [4:0] wa, bit [7:0] wd, bit [1:0] st);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; xfer_stb = st;
        rd_addr = rd_addr + 5'd1;
    endtask

    task automatic wr(bit [4:0] wa, bit [7:0] wd);
        cyc(1'b1, wa, wd, 2'b00);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 5'd0, 8'd0, 2'b00);
    endtask

    task automatic sweep();
        for (int i = 0; i < 32; i++) cyc(1'b0, 5'd0, 8'd0, 2'b00);
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: control bytes read 0 and no end pulse after reset
        sweep();
        // R2: pointers, byte order and the unstored top nibble
        wr(5'h00, 8'h45); wr(5'h01, 8'h23); wr(5'h02, 8'hF1);
        wr(5'h04, 8'hDE); wr(5'h05, 8'hBC); wr(5'h06, 8'h3A);
        wr(5'h08, 8'h03); wr(5'h09, 8'h00);
        wr(5'h10, 8'h00); wr(5'h11, 8'h80); wr(5'h12, 8'h07);
        wr(5'h14, 8'hFE); wr(5'h15, 8'hFF); wr(5'h16, 8'hFF);
        wr(5'h18, 8'h01); wr(5'h19, 8'h00);
        init_done = 1'b1;
        sweep();
        // R5: counter reads working count, not the new reload value
        wr(5'h0C, 8'h11); // R6: ch0 on, src increments, dst fixed, single
        wr(5'h08, 8'h07);
        sweep();
        // R3: fixed dst write while enabled is dropped
        wr(5'h04, 8'h55);
        // R4: incrementing src write accepted, read still shows live copy
        wr(5'h00, 8'h99);
        // R7: strobes step src by 1 and count down
        cyc(1'b0, 5'd0, 8'd0, 2'b01); idle(2);
        cyc(1'b0, 5'd0, 8'd0, 2'b01);
        sweep();
        cyc(1'b0, 5'd0, 8'd0, 2'b01);
        // R8: fourth strobe underflows, pulse and stop
        cyc(1'b0, 5'd0, 8'd0, 2'b01); idle(2);
        // R7: strobe on disabled channel ignored
        cyc(1'b0, 5'd0, 8'd0, 2'b01);
        sweep();
        // R9: ch1 repeat, both increment, unit 2; R10: ch0 untouched
        wr(5'h1C, 8'h1F);
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 5'd0, 8'd0, 2'b10); idle(1);
        end
        sweep();
        wr(5'h1C, 8'h00);
        // random phase over all behaviour, both channels
        for (int i = 0; i < 6000; i++) begin
            bit we;
            bit [4:0] a;
            bit [7:0] d;
            we = ($urandom % 3) == 0;
            a = 5'($urandom);
            d = 8'($urandom);
            if (a[3:0] == 4'd9) d = 8'h00;
            if (a[3:0] == 4'd8) d = d & 8'h07;
            cyc(we, a, d, 2'($urandom));
        end
        idle(2);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule